// File: doc/BRIEF.md
# Card Clock and Bit-Period Generator

This block derives the clock driven to a contact smart card from the crystal timing, and it also derives the bit-period tick (one elementary time unit, etu) that the character layer uses to sample and send bits. The block runs on `clk`, which runs at twice the crystal frequency. Because of this, a divide-by-1 card clock is still a registered output with a 50 % duty cycle. The card clock divides the crystal by 1, 2, 4 or 8. The etu is a count of card-clock rising edges, equal to a prescaler times a divider. A double-speed bit halves that count.

Software-facing logic sends requests through one configuration port. A request either selects a card clock or loads new etu settings. Before a clock request can take effect, the block compares the resulting frequency with the maximum frequency allowed for the card's present Fi class, which arrives on `cardFmaxKhz`. A request that would overclock the card is refused and the clock is left as it was. Every request is answered one cycle later by a done pulse and a status byte. An accepted divider is applied only when the card clock falls, so that no short pulse reaches the card. New etu settings take effect at the next etu boundary.

Top module: `cardclk_etu_gen`

## Requirements
- R1: After reset the active division code is 2 (crystal divided by 4), `cardClk` is low, `etuTick` and `cfgDone` are low, `cfgStatus` is 0x00, and the etu settings are prescaler 31, divider 12, double-speed off (372 card clocks per etu).
- R2: With active division code k (request codes 0x00, 0x02, 0x04, 0x06 map to k = 0, 1, 2, 3), `cardClk` is high for 2^k `clk` cycles and then low for 2^k cycles, so its period is 2·2^k cycles.
- R3: An accepted clock change takes effect only at a falling edge of `cardClk`. The high phase in progress completes with the old length, and the low phase that follows uses the new length. `activeDiv` changes on that same edge.
- R4: A clock request is refused with status 0xE1 when XTAL_KHZ / 2^k exceeds `cardFmaxKhz`. With a 14745 kHz crystal and a 6000 kHz limit, this refuses codes 0x00 and 0x02. `activeDiv` and `cardClk` timing stay unchanged.
- R5: A clock request whose code is not 0x00, 0x02, 0x04 or 0x06 is refused with status 0x35 and changes nothing.
- R6: `cfgDone` pulses in the cycle after each `cfgValid`, and `cfgStatus` holds the result from then until the next request. An accepted request reports 0x00.
- R7: `etuTick` is a one-cycle pulse, raised as `cardClk` rises, once every prescaler·divider card-clock rising edges.
- R8: With the double-speed bit set, the etu lasts (prescaler·divider)/2 card-clock rising edges, rounded down and at least 1.
- R9: An etu request whose prescaler or divider is zero is refused with status 0x35, and the etu length stays unchanged.
- R10: Accepted etu settings take effect at the next `etuTick`. The etu in progress completes with the old length, and the count restarts from zero with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at twice the crystal frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | One-cycle configuration request strobe |
| cfgIsEtu | input | 1 | 0: clock-select request, 1: etu-settings request |
| cfgClkCode | input | 8 | Clock-select code (0x00/0x02/0x04/0x06) |
| cfgPrescale | input | PRE_W | Etu prescaler value |
| cfgDivider | input | DIV_W | Etu divider value |
| cfgDouble | input | 1 | Double-speed bit, halves the clocks per etu |
| cardFmaxKhz | input | FMAX_W | Highest card clock allowed for the current Fi class, in kHz |
| cardClk | output | 1 | Clock to the card |
| etuTick | output | 1 | One-cycle pulse on each etu boundary |
| cfgDone | output | 1 | Pulse marking that a request was processed |
| cfgStatus | output | 8 | Result of the last request: 0x00, 0xE1 or 0x35 |
| activeDiv | output | 2 | Division code k currently applied to the card clock |

## Verification
A wrong divider or phase counter shows at the ports within one card half-period, at most 8 cycles: either `cardClk` toggles at the wrong time or `activeDiv` changes while the card clock is high. A corrupted etu counter or a stale set of etu settings shows only at the next `etuTick`, up to a full etu later (2976 cycles at the reset setting). The bench therefore measures tick spacing across each settings change, and its reference model also compares every output on every cycle. An error in the decode or the frequency check shows on `cfgStatus` and `cfgDone` in the cycle right after the request. A refused request that changed state anyway shows later as a shifted clock or a shifted tick spacing.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  localparam logic [7:0] STS_OK        = 8'h00;
  localparam logic [7:0] STS_BAD_PARAM = 8'h35;
  localparam logic [7:0] STS_CLK_RANGE = 8'hE1;

  localparam int          NUM_DIV     = 4;
  localparam logic [1:0]  RESET_SHIFT = 2'd2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       clkLoad;
    logic [1:0] clkShift;
    logic       etuLoad;
  } cfg_strobe_t;

endpackage

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int XTAL_KHZ = 14745,
  parameter int FMAX_W   = 16,
  parameter int PRE_W    = 8,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgIsEtu,
  input  logic [7:0]        cfgClkCode,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [DIV_W-1:0]  cfgDivider,
  input  logic [FMAX_W-1:0] cardFmaxKhz,
  output cfg_strobe_t       strb,
  output logic              cfgDone,
  output logic [7:0]        cfgStatus
);

  localparam logic [31:0] XTAL_U = 32'(XTAL_KHZ);

  logic [NUM_DIV-1:0] codeHit;
  logic [1:0]         codeShift;
  logic               codeKnown;
  logic [31:0]        rateKhz;
  logic               tooFast;
  logic               etuZero;
  logic [7:0]         nextStatus;

  // One comparator per legal clock-select code (even codes 0,2,4,6).
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_code
    assign codeHit[g] = (cfgClkCode == 8'(2 * g));
  end

  always_comb begin
    codeShift = 2'd0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (codeHit[i]) codeShift = 2'(i);
    end
  end

  assign codeKnown = |codeHit;
  assign rateKhz   = XTAL_U >> codeShift;
  assign tooFast   = rateKhz > 32'(cardFmaxKhz);
  assign etuZero   = (cfgPrescale == '0) || (cfgDivider == '0);

  always_comb begin
    strb       = '0;
    nextStatus = STS_OK;
    if (cfgValid) begin
      if (!cfgIsEtu) begin
        if (!codeKnown) begin
          nextStatus = STS_BAD_PARAM;
        end else if (tooFast) begin
          nextStatus = STS_CLK_RANGE;
        end else begin
          strb.clkLoad  = 1'b1;
          strb.clkShift = codeShift;
        end
      end else begin
        if (etuZero) begin
          nextStatus = STS_BAD_PARAM;
        end else begin
          strb.etuLoad = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDone   <= 1'b0;
      cfgStatus <= STS_OK;
    end else begin
      cfgDone <= cfgValid;
      if (cfgValid) cfgStatus <= nextStatus;
    end
  end

  AST_REFUSED_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDone && cfgStatus != STS_OK) |-> !$past(strb.clkLoad || strb.etuLoad)); // R4

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> (cfgStatus == STS_OK || cfgStatus == STS_BAD_PARAM ||
                 cfgStatus == STS_CLK_RANGE)); // R6

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clkLoad && strb.etuLoad)); // R5

endmodule

// File: rtl/cardclk_datapath.sv
module cardclk_datapath
  import cardclk_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int DIV_W       = 8,
  parameter int DEF_PRESCALE = 31,
  parameter int DEF_DIVIDER  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_strobe_t      strb,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic             cfgDouble,
  output logic             cardClk,
  output logic             etuTick,
  output logic [1:0]       activeDiv
);

  localparam int LEN_W = PRE_W + DIV_W;

  // Card clock divider state
  logic [1:0] divShift;
  logic [2:0] halfCnt;
  logic [2:0] halfLimit;
  logic       toggle;
  logic       cardRise;
  logic       clkPend;
  logic [1:0] pendShift;

  // Etu state
  logic             etuPend;
  logic [PRE_W-1:0] pendPre;
  logic [DIV_W-1:0] pendDv;
  logic             pendDbl;
  logic [PRE_W-1:0] actPre;
  logic [DIV_W-1:0] actDv;
  logic             actDbl;
  logic [LEN_W-1:0] etuCnt;
  logic [LEN_W-1:0] fullLen;
  logic [LEN_W-1:0] effLen;
  logic             etuLast;

  assign halfLimit = (3'd1 << divShift) - 3'd1;
  assign toggle    = (halfCnt == halfLimit);
  assign cardRise  = toggle && !cardClk;
  assign activeDiv = divShift;

  // Card clock: toggles every 2^divShift cycles; divider swaps on a falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divShift  <= RESET_SHIFT;
      halfCnt   <= 3'd0;
      cardClk   <= 1'b0;
      clkPend   <= 1'b0;
      pendShift <= RESET_SHIFT;
    end else begin
      if (toggle) begin
        cardClk <= ~cardClk;
        halfCnt <= 3'd0;
        if (cardClk && clkPend) begin
          divShift <= pendShift;
          clkPend  <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + 3'd1;
      end
      if (strb.clkLoad) begin
        clkPend   <= 1'b1;
        pendShift <= strb.clkShift;
      end
    end
  end

  // Etu length from the active settings.
  always_comb begin
    fullLen = LEN_W'(actPre) * LEN_W'(actDv);
    effLen  = actDbl ? (fullLen >> 1) : fullLen;
    if (effLen == '0) effLen = LEN_W'(1);
  end

  assign etuLast = (etuCnt >= effLen - LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      etuCnt  <= '0;
      etuTick <= 1'b0;
      etuPend <= 1'b0;
      pendPre <= PRE_W'(DEF_PRESCALE);
      pendDv  <= DIV_W'(DEF_DIVIDER);
      pendDbl <= 1'b0;
      actPre  <= PRE_W'(DEF_PRESCALE);
      actDv   <= DIV_W'(DEF_DIVIDER);
      actDbl  <= 1'b0;
    end else begin
      etuTick <= 1'b0;
      if (cardRise) begin
        if (etuLast) begin
          etuTick <= 1'b1;
          etuCnt  <= '0;
          if (etuPend) begin
            actPre  <= pendPre;
            actDv   <= pendDv;
            actDbl  <= pendDbl;
            etuPend <= 1'b0;
          end
        end else begin
          etuCnt <= etuCnt + LEN_W'(1);
        end
      end
      if (strb.etuLoad) begin
        etuPend <= 1'b1;
        pendPre <= cfgPrescale;
        pendDv  <= cfgDivider;
        pendDbl <= cfgDouble;
      end
    end
  end

  AST_DIV_SWAP_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divShift) |-> $fell(cardClk)); // R3

  AST_CLK_HOLD_MID_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (halfCnt != 3'd0) |-> $stable(cardClk)); // R2

  AST_TICK_WITH_RISE: assert property (@(posedge clk) disable iff (!rstN)
    etuTick |-> $rose(cardClk)); // R7

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    etuTick |=> !etuTick); // R7

  AST_ETU_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    etuTick |-> (etuCnt == '0)); // R10

endmodule

// File: rtl/cardclk_etu_gen.sv
module cardclk_etu_gen
  import cardclk_pkg::*;
#(
  parameter int XTAL_KHZ     = 14745,
  parameter int FMAX_W       = 16,
  parameter int PRE_W        = 8,
  parameter int DIV_W        = 8,
  parameter int DEF_PRESCALE = 31,
  parameter int DEF_DIVIDER  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgIsEtu,
  input  logic [7:0]        cfgClkCode,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [DIV_W-1:0]  cfgDivider,
  input  logic              cfgDouble,
  input  logic [FMAX_W-1:0] cardFmaxKhz,
  output logic              cardClk,
  output logic              etuTick,
  output logic              cfgDone,
  output logic [7:0]        cfgStatus,
  output logic [1:0]        activeDiv
);

  cfg_strobe_t strb;

  cardclk_ctrl #(
    .XTAL_KHZ(XTAL_KHZ), .FMAX_W(FMAX_W), .PRE_W(PRE_W), .DIV_W(DIV_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIsEtu(cfgIsEtu),
    .cfgClkCode(cfgClkCode), .cfgPrescale(cfgPrescale), .cfgDivider(cfgDivider),
    .cardFmaxKhz(cardFmaxKhz), .strb(strb), .cfgDone(cfgDone), .cfgStatus(cfgStatus)
  );

  cardclk_datapath #(
    .PRE_W(PRE_W), .DIV_W(DIV_W),
    .DEF_PRESCALE(DEF_PRESCALE), .DEF_DIVIDER(DEF_DIVIDER)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgPrescale(cfgPrescale),
    .cfgDivider(cfgDivider), .cfgDouble(cfgDouble), .cardClk(cardClk),
    .etuTick(etuTick), .activeDiv(activeDiv)
  );

endmodule

// File: tb/cardclk_etu_gen_tb_top.sv
`timescale 1ns/1ps
module cardclk_etu_gen_tb_top;

  localparam int XTAL = 14745;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic        cfgIsEtu = 1'b0;
  logic [7:0]  cfgClkCode = 8'h00;
  logic [7:0]  cfgPrescale = 8'd0;
  logic [7:0]  cfgDivider = 8'd0;
  logic        cfgDouble = 1'b0;
  logic [15:0] cardFmaxKhz = 16'd6000;
  logic        cardClk, etuTick, cfgDone;
  logic [7:0]  cfgStatus;
  logic [1:0]  activeDiv;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  cardclk_etu_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIsEtu(cfgIsEtu),
    .cfgClkCode(cfgClkCode), .cfgPrescale(cfgPrescale), .cfgDivider(cfgDivider),
    .cfgDouble(cfgDouble), .cardFmaxKhz(cardFmaxKhz), .cardClk(cardClk),
    .etuTick(etuTick), .cfgDone(cfgDone), .cfgStatus(cfgStatus), .activeDiv(activeDiv)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int mShift, mHalf, mCard, mClkPend, mPendShift;
  int mPre, mDv, mDbl, mEtuPend, mPPre, mPDv, mPDbl, mCnt, mTick;
  int mDone, mStatus, mLen, mRate;
  bit mTog, mRise;

  always @(posedge clk) begin
    if (!rstN) begin
      mShift = 2; mHalf = 0; mCard = 0; mClkPend = 0; mPendShift = 2;
      mPre = 31; mDv = 12; mDbl = 0; mEtuPend = 0; mPPre = 31; mPDv = 12; mPDbl = 0;
      mCnt = 0; mTick = 0; mDone = 0; mStatus = 0;
    end else begin
      mTog  = (mHalf == (1 << mShift) - 1);
      mRise = mTog && (mCard == 0);
      mLen = mPre * mDv;
      if (mDbl != 0) mLen = mLen / 2;
      if (mLen < 1) mLen = 1;
      mTick = 0;
      if (mRise) begin
        if (mCnt >= mLen - 1) begin
          mTick = 1; mCnt = 0;
          if (mEtuPend != 0) begin
            mPre = mPPre; mDv = mPDv; mDbl = mPDbl; mEtuPend = 0;
          end
        end else mCnt++;
      end
      if (mTog) begin
        if (mCard == 1 && mClkPend != 0) begin
          mShift = mPendShift; mClkPend = 0;
        end
        mCard = 1 - mCard; mHalf = 0;
      end else mHalf++;
      mDone = cfgValid ? 1 : 0;
      if (cfgValid) begin
        if (!cfgIsEtu) begin
          if (cfgClkCode == 8'h00 || cfgClkCode == 8'h02 ||
              cfgClkCode == 8'h04 || cfgClkCode == 8'h06) begin
            mRate = XTAL / (1 << (cfgClkCode / 2));
            if (mRate > int'(cardFmaxKhz)) mStatus = 8'hE1;
            else begin
              mStatus = 0; mClkPend = 1; mPendShift = cfgClkCode / 2;
            end
          end else mStatus = 8'h35;
        end else begin
          if (cfgPrescale == 0 || cfgDivider == 0) mStatus = 8'h35;
          else begin
            mStatus = 0; mEtuPend = 1;
            mPPre = cfgPrescale; mPDv = cfgDivider; mPDbl = cfgDouble ? 1 : 0;
          end
        end
      end
    end
  end

  // Per-cycle comparison and divider-swap monitor, sampled on the falling edge.
  logic prevCard = 1'b0;
  logic [1:0] prevDiv = 2'd2;
  always @(negedge clk) begin
    if (rstN) begin
      chk(cardClk == 1'(mCard), "R2 cardClk vs model", int'(cardClk), mCard);
      chk(etuTick == 1'(mTick), "R7 etuTick vs model", int'(etuTick), mTick);
      chk(cfgDone == 1'(mDone), "R6 cfgDone vs model", int'(cfgDone), mDone);
      chk(cfgStatus == 8'(mStatus), "R6 cfgStatus vs model", int'(cfgStatus), mStatus);
      chk(activeDiv == 2'(mShift), "R3 activeDiv vs model", int'(activeDiv), mShift);
      if (activeDiv != prevDiv)
        chk(prevCard && !cardClk, "R3 swap only on falling edge", int'(cardClk), 0);
    end
    prevCard = cardClk;
    prevDiv  = activeDiv;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic waitTick(output int c);
    do @(negedge clk); while (!etuTick);
    c = cyc;
  endtask

  task automatic waitRise(output int c);
    do @(negedge clk); while (cardClk);
    do @(negedge clk); while (!cardClk);
    c = cyc;
  endtask

  task automatic reqClk(input logic [7:0] code, input logic [7:0] expSts, input string req);
    @(negedge clk);
    cfgValid = 1'b1; cfgIsEtu = 1'b0; cfgClkCode = code;
    @(negedge clk);
    cfgValid = 1'b0;
    chk(cfgDone == 1'b1, req, int'(cfgDone), 1);
    chk(cfgStatus == expSts, req, int'(cfgStatus), int'(expSts));
  endtask

  task automatic reqEtu(input int pre, input int dv, input bit dbl,
                        input logic [7:0] expSts, input string req);
    @(negedge clk);
    cfgValid = 1'b1; cfgIsEtu = 1'b1;
    cfgPrescale = 8'(pre); cfgDivider = 8'(dv); cfgDouble = dbl;
    @(negedge clk);
    cfgValid = 1'b0;
    chk(cfgDone == 1'b1, req, int'(cfgDone), 1);
    chk(cfgStatus == expSts, req, int'(cfgStatus), int'(expSts));
  endtask

  initial begin
    int a, b, c;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(activeDiv == 2'd2, "R1 reset divider", int'(activeDiv), 2);
    chk(cardClk == 1'b0, "R1 reset cardClk", int'(cardClk), 0);
    chk(etuTick == 1'b0 && cfgDone == 1'b0, "R1 reset strobes", int'(etuTick), 0);
    chk(cfgStatus == 8'h00, "R1 reset status", int'(cfgStatus), 0);

    // R2: divide by 4 -> period 8
    waitRise(a); waitRise(b);
    chk(b - a == 8, "R2 period div4", b - a, 8);
    // R1/R7: default etu 372 card clocks
    waitTick(a); waitTick(b);
    chk(b - a == 2976, "R1 R7 default etu", b - a, 2976);

    // R4: overclock refused with 6000 kHz limit
    cardFmaxKhz = 16'd6000;
    reqClk(8'h00, 8'hE1, "R4 refuse div1");
    reqClk(8'h02, 8'hE1, "R4 refuse div2");
    repeat (20) @(negedge clk);
    chk(activeDiv == 2'd2, "R4 divider unchanged", int'(activeDiv), 2);
    waitRise(a); waitRise(b);
    chk(b - a == 8, "R4 period unchanged", b - a, 8);

    // R5: unknown code
    reqClk(8'h05, 8'h35, "R5 unknown code");
    repeat (20) @(negedge clk);
    chk(activeDiv == 2'd2, "R5 divider unchanged", int'(activeDiv), 2);

    // R6 / R3: raise limit, divide by 1 accepted
    cardFmaxKhz = 16'd20000;
    reqClk(8'h00, 8'h00, "R6 accept div1");
    repeat (20) @(negedge clk);
    chk(activeDiv == 2'd0, "R3 divider applied", int'(activeDiv), 0);
    waitRise(a); waitRise(b);
    chk(b - a == 2, "R2 period div1", b - a, 2);

    // R10 / R8: new etu waits for boundary, double speed halves
    waitTick(a);
    waitTick(a);
    repeat (10) @(negedge clk);
    reqEtu(31, 12, 1'b1, 8'h00, "R6 accept etu");
    waitTick(b);
    chk(b - a == 744, "R10 old etu completes", b - a, 744);
    waitTick(c);
    chk(c - b == 372, "R8 double speed etu", c - b, 372);

    // R9: zero prescaler refused
    reqEtu(0, 12, 1'b0, 8'h35, "R9 zero prescaler");
    waitTick(a); waitTick(b); waitTick(c);
    chk(c - b == 372, "R9 etu unchanged", c - b, 372);

    // R7: small etu
    reqEtu(3, 2, 1'b0, 8'h00, "R7 small etu");
    waitTick(a); waitTick(b); waitTick(c);
    chk(c - b == 12, "R7 etu 6 clocks div1", c - b, 12);

    // R2: divide by 8
    reqClk(8'h06, 8'h00, "R6 accept div8");
    repeat (40) @(negedge clk);
    chk(activeDiv == 2'd3, "R3 divider 8 applied", int'(activeDiv), 3);
    waitRise(a); waitRise(b);
    chk(b - a == 16, "R2 period div8", b - a, 16);
    waitTick(a); waitTick(b); waitTick(c);
    chk(c - b == 96, "R7 etu at div8", c - b, 96);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule